// File: doc/BRIEF.md
# MIDI Real-Time Sync Decoder

This block sits on an incoming MIDI byte stream, one byte per accepted cycle, and pulls out the single-byte real-time messages that a receiver uses to follow an external tempo source. Timing clocks, start, continue, stop, active sensing and system reset each raise their own one-cycle event strobe. The block also keeps a running/stopped transport state. All other bytes go on to a downstream message parser with the real-time bytes removed, so a clock that arrives in the middle of a note message does not break that message apart.

While the transport runs, each timing clock advances a clock-position counter. Every twenty-fourth clock since the last start raises a quarter-note strobe. Clocks received while stopped are still reported, so a follower can lock to the rate before playback begins, but they do not move the position. A reset byte is reported through a request output and is never passed on. This keeps reset loops from forming between devices.

Top module: `midi_rt_sync`

## Requirements
- R1: A byte below F8h accepted with `in_valid` appears on `out_byte` with `out_valid` high exactly one cycle later. Pass-through bytes keep their input order.
- R2: No byte in the range F8h to FFh ever appears on the output. `out_valid` is low in the cycle after such a byte.
- R3: A timing clock byte (F8h) raises `clk_pulse` for one cycle, one cycle after it is accepted. This happens whether the transport is running or stopped.
- R4: Start (FAh) raises `start_pulse`, sets `running`, clears `clk_pos` to 0 and restarts the quarter-note phase.
- R5: Continue (FBh) raises `cont_pulse` and sets `running`. It leaves `clk_pos` and the quarter-note phase unchanged.
- R6: Stop (FCh) raises `stop_pulse` and clears `running`. Clocks received while stopped leave `clk_pos` unchanged.
- R7: While running, each timing clock increments `clk_pos` by one, wrapping at 2^POS_W. `quarter_pulse` rises with the clock that completes each group of 24 clocks counted from the last start or reset, and continue does not restart that count.
- R8: Active sensing (FEh) raises `sense_pulse` only. The transport state and position are unaffected.
- R9: System reset (FFh) raises `reset_req` for one cycle, clears `running` and `clk_pos`, and restarts the quarter-note phase.
- R10: The undefined real-time codes F9h and FDh are removed from the stream and have no other effect.
- R11: After the `rst` input, all outputs are 0 and the transport is stopped at position 0.
- R12: A cycle with `in_valid` low produces no output byte, no strobe and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` holds a received byte this cycle |
| in_byte | input | 8 | Received MIDI byte |
| out_valid | output | 1 | `out_byte` holds a pass-through byte |
| out_byte | output | 8 | Stream with real-time bytes removed |
| clk_pulse | output | 1 | Timing clock received |
| start_pulse | output | 1 | Start received |
| cont_pulse | output | 1 | Continue received |
| stop_pulse | output | 1 | Stop received |
| sense_pulse | output | 1 | Active sensing received |
| reset_req | output | 1 | System reset received; request to reset locally |
| running | output | 1 | Transport running |
| quarter_pulse | output | 1 | Quarter-note boundary reached |
| clk_pos | output | POS_W | Clocks counted while running since start |

## Verification
If the sub-quarter phase counter is wrong, the error shows as a `quarter_pulse` on the wrong clock. This is visible within 24 running clocks, and after a continue it shows whether the phase was kept. A wrong position count shows on `clk_pos` in the cycle after the clock that should have moved it, or should have left it alone while stopped. A misclassified code shows at once, either as a real-time byte leaking onto `out_byte` or as a missing or extra strobe. Long mixed streams with real-time bytes placed between data bytes confirm that the order of the data bytes is kept.

// File: rtl/midi_rt_pkg.sv
package midi_rt_pkg;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_CLOCK,
    EV_START,
    EV_CONT,
    EV_STOP,
    EV_SENSE,
    EV_RESET,
    EV_DROP
  } rt_ev_e;

  localparam logic [7:0] RT_CLOCK = 8'hF8;
  localparam logic [7:0] RT_START = 8'hFA;
  localparam logic [7:0] RT_CONT  = 8'hFB;
  localparam logic [7:0] RT_STOP  = 8'hFC;
  localparam logic [7:0] RT_SENSE = 8'hFE;
  localparam logic [7:0] RT_RESET = 8'hFF;

  function automatic logic is_realtime(input logic [7:0] b);
    return b[7:3] == 5'b11111;
  endfunction

  function automatic rt_ev_e rt_decode(input logic [7:0] b);
    rt_ev_e e;
    if (!is_realtime(b)) e = EV_NONE;
    else begin
      case (b)
        RT_CLOCK: e = EV_CLOCK;
        RT_START: e = EV_START;
        RT_CONT:  e = EV_CONT;
        RT_STOP:  e = EV_STOP;
        RT_SENSE: e = EV_SENSE;
        RT_RESET: e = EV_RESET;
        default:  e = EV_DROP;
      endcase
    end
    return e;
  endfunction

endpackage

// File: rtl/rt_classify.sv
module rt_classify
  import midi_rt_pkg::*;
(
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       pass_valid,
  output logic       ev_valid,
  output rt_ev_e     ev
);
  always_comb begin
    ev         = rt_decode(in_byte);
    ev_valid   = in_valid && (ev != EV_NONE);
    pass_valid = in_valid && (ev == EV_NONE);
  end
endmodule

// File: rtl/rt_passthru.sv
module rt_passthru #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pass_valid,
  input  logic [DATA_W-1:0] pass_byte,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= pass_valid;
      if (pass_valid) out_byte <= pass_byte;
    end
  end

  // R2: real-time codes never leave on the data path
  a_r2_no_rt_out: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_byte[DATA_W-1:DATA_W-5] != 5'b11111));

  // R1: one-cycle latency, byte unchanged
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid) && out_byte == $past(in_byte)));
endmodule

// File: rtl/rt_transport.sv
module rt_transport
  import midi_rt_pkg::*;
#(
  parameter int CLKS_PER_QTR = 24,
  parameter int POS_W        = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  rt_ev_e           ev,
  output logic             clk_pulse,
  output logic             start_pulse,
  output logic             cont_pulse,
  output logic             stop_pulse,
  output logic             sense_pulse,
  output logic             reset_req,
  output logic             running,
  output logic             quarter_pulse,
  output logic [POS_W-1:0] clk_pos
);
  localparam int SUB_W = (CLKS_PER_QTR > 1) ? $clog2(CLKS_PER_QTR) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLKS_PER_QTR - 1);

  logic [SUB_W-1:0] sub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_pulse     <= 1'b0;
      start_pulse   <= 1'b0;
      cont_pulse    <= 1'b0;
      stop_pulse    <= 1'b0;
      sense_pulse   <= 1'b0;
      reset_req     <= 1'b0;
      quarter_pulse <= 1'b0;
      running       <= 1'b0;
      clk_pos       <= '0;
      sub_q         <= '0;
    end else begin
      clk_pulse     <= 1'b0;
      start_pulse   <= 1'b0;
      cont_pulse    <= 1'b0;
      stop_pulse    <= 1'b0;
      sense_pulse   <= 1'b0;
      reset_req     <= 1'b0;
      quarter_pulse <= 1'b0;
      if (ev_valid) begin
        case (ev)
          EV_CLOCK: begin
            clk_pulse <= 1'b1;
            if (running) begin
              clk_pos <= clk_pos + POS_W'(1);
              if (sub_q == SUB_LAST) begin
                sub_q         <= '0;
                quarter_pulse <= 1'b1;
              end else begin
                sub_q <= sub_q + SUB_W'(1);
              end
            end
          end
          EV_START: begin
            start_pulse <= 1'b1;
            running     <= 1'b1;
            clk_pos     <= '0;
            sub_q       <= '0;
          end
          EV_CONT: begin
            cont_pulse <= 1'b1;
            running    <= 1'b1;
          end
          EV_STOP: begin
            stop_pulse <= 1'b1;
            running    <= 1'b0;
          end
          EV_SENSE: sense_pulse <= 1'b1;
          EV_RESET: begin
            reset_req <= 1'b1;
            running   <= 1'b0;
            clk_pos   <= '0;
            sub_q     <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  // R6: the transport only halts on stop or reset
  a_r6_halt_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> $past(ev_valid && (ev == EV_STOP || ev == EV_RESET)));

  // R7: quarter strobe only with a clock while running
  a_r7_quarter_with_clk: assert property (@(posedge clk) disable iff (rst)
    quarter_pulse |-> (clk_pulse && running));

  // R7: a running clock moves the position by exactly one
  a_r7_pos_step: assert property (@(posedge clk) disable iff (rst)
    (clk_pulse && $past(running)) |-> (clk_pos == $past(clk_pos) + POS_W'(1)));

  // R9: reset request leaves the transport stopped at zero
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (!running && clk_pos == '0));

  // R8: active sensing touches no transport state
  a_r8_sense_inert: assert property (@(posedge clk) disable iff (rst)
    sense_pulse |-> ($stable(running) && $stable(clk_pos)));
endmodule

// File: rtl/midi_rt_sync.sv
module midi_rt_sync
  import midi_rt_pkg::*;
#(
  parameter int CLKS_PER_QTR = 24,
  parameter int POS_W        = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             clk_pulse,
  output logic             start_pulse,
  output logic             cont_pulse,
  output logic             stop_pulse,
  output logic             sense_pulse,
  output logic             reset_req,
  output logic             running,
  output logic             quarter_pulse,
  output logic [POS_W-1:0] clk_pos
);
  logic   pass_valid;
  logic   ev_valid;
  rt_ev_e ev;

  rt_classify u_cls (
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .pass_valid(pass_valid),
    .ev_valid  (ev_valid),
    .ev        (ev)
  );

  rt_passthru #(.DATA_W(8)) u_pass (
    .clk       (clk),
    .rst       (rst),
    .pass_valid(pass_valid),
    .pass_byte (in_byte),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .out_valid (out_valid),
    .out_byte  (out_byte)
  );

  rt_transport #(.CLKS_PER_QTR(CLKS_PER_QTR), .POS_W(POS_W)) u_trn (
    .clk          (clk),
    .rst          (rst),
    .ev_valid     (ev_valid),
    .ev           (ev),
    .clk_pulse    (clk_pulse),
    .start_pulse  (start_pulse),
    .cont_pulse   (cont_pulse),
    .stop_pulse   (stop_pulse),
    .sense_pulse  (sense_pulse),
    .reset_req    (reset_req),
    .running      (running),
    .quarter_pulse(quarter_pulse),
    .clk_pos      (clk_pos)
  );

  // R3: at most one event strobe per cycle, and never alongside a data byte
  a_r3_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clk_pulse, start_pulse, cont_pulse, stop_pulse, sense_pulse, reset_req, out_valid}));
endmodule

// File: tb/sim_midi_rt_sync.sv
module sim_midi_rt_sync;
  localparam int CLK_PERIOD = 10;
  localparam int POS_W      = 16;
  localparam int QTR        = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic out_valid, clk_pulse, start_pulse, cont_pulse, stop_pulse;
  logic sense_pulse, reset_req, running, quarter_pulse;
  logic [7:0] out_byte;
  logic [POS_W-1:0] clk_pos;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit m_run = 0;
  int m_pos = 0;
  int m_sub = 0;
  bit e_ov = 0;
  logic [7:0] e_ob = 8'h00;
  logic [6:0] e_pul = '0;   // {clk,start,cont,stop,sense,reset,quarter}
  logic [7:0] data_q[$];    // expected pass-through order

  always #(CLK_PERIOD/2) clk = ~clk;

  midi_rt_sync #(.CLKS_PER_QTR(QTR), .POS_W(POS_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .clk_pulse(clk_pulse),
    .start_pulse(start_pulse), .cont_pulse(cont_pulse), .stop_pulse(stop_pulse),
    .sense_pulse(sense_pulse), .reset_req(reset_req), .running(running),
    .quarter_pulse(quarter_pulse), .clk_pos(clk_pos)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input bit v, input logic [7:0] b);
    if (!v) return "R12";
    if (b < 8'hF8) return "R1";
    case (b)
      8'hF8: return "R7";
      8'hFA: return "R4";
      8'hFB: return "R5";
      8'hFC: return "R6";
      8'hFE: return "R8";
      8'hFF: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input bit v, input logic [7:0] b);
    e_ov = 0;
    e_pul = '0;
    if (!v) return;
    if (b < 8'hF8) begin
      e_ov = 1; e_ob = b; data_q.push_back(b);
      return;
    end
    case (b)
      8'hF8: begin
        e_pul[6] = 1;
        if (m_run) begin
          m_pos = (m_pos + 1) % (1 << POS_W);
          m_sub = m_sub + 1;
          if (m_sub == QTR) begin m_sub = 0; e_pul[0] = 1; end
        end
      end
      8'hFA: begin e_pul[5] = 1; m_run = 1; m_pos = 0; m_sub = 0; end
      8'hFB: begin e_pul[4] = 1; m_run = 1; end
      8'hFC: begin e_pul[3] = 1; m_run = 0; end
      8'hFE: e_pul[2] = 1;
      8'hFF: begin e_pul[1] = 1; m_run = 0; m_pos = 0; m_sub = 0; end
      default: ;
    endcase
  endtask

  task automatic step(input bit v, input logic [7:0] b);
    string t;
    logic [7:0] exp_b;
    in_valid = v; in_byte = b;
    @(posedge clk);
    #1;
    model(v, b);
    @(negedge clk);
    t = tag_of(v, b);
    if (v && b >= 8'hF8) chk("R2", {31'd0, out_valid}, 32'd0, "out_valid on real-time byte");
    else chk(t, {31'd0, out_valid}, {31'd0, e_ov}, "out_valid");
    if (e_ov) begin
      exp_b = data_q.pop_front();
      chk("R1", {24'd0, out_byte}, {24'd0, exp_b}, "out_byte order");
    end
    chk((v && b == 8'hF8) ? "R3" : t,
        {25'd0, clk_pulse, start_pulse, cont_pulse, stop_pulse, sense_pulse, reset_req, quarter_pulse},
        {25'd0, e_pul}, "strobes");
    chk(t, {31'd0, running}, {31'd0, m_run}, "running");
    chk(t, {16'd0, clk_pos}, m_pos, "clk_pos");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11", {20'd0, out_valid, clk_pulse, start_pulse, cont_pulse, stop_pulse,
                sense_pulse, reset_req, running, quarter_pulse, 3'd0}, 32'd0, "strobes after reset");
    chk("R11", {16'd0, clk_pos}, 32'd0, "clk_pos after reset");

    // R1 data pass-through, R12 idle cycles
    step(1, 8'h90); step(1, 8'h3C); step(0, 8'hF8); step(1, 8'h64);
    // R3, R6: clocks while stopped do not move position
    for (int i = 0; i < 5; i++) step(1, 8'hF8);
    // R4 start, R7 run two quarters with interleaved data
    step(1, 8'hFA);
    for (int i = 0; i < 2 * QTR; i++) begin
      step(1, 8'hF8);
      if (i % 7 == 3) begin step(1, 8'h80); step(1, 8'hF8); step(1, 8'h40); i++; end
    end
    // R8 sense, R10 undefined codes
    step(1, 8'hFE); step(1, 8'hF9); step(1, 8'hFD); step(1, 8'h12);
    // R6 stop, clocks while stopped, R5 continue keeps position and phase
    for (int i = 0; i < 10; i++) step(1, 8'hF8);
    step(1, 8'hFC);
    for (int i = 0; i < 6; i++) step(1, 8'hF8);
    step(1, 8'hFB);
    for (int i = 0; i < QTR; i++) step(1, 8'hF8);
    // R9 system reset mid-run
    step(1, 8'hFF);
    step(1, 8'hF8); step(1, 8'hFB);
    for (int i = 0; i < 30; i++) step(1, 8'hF8);
    // R4 restart clears phase
    step(1, 8'hFA);
    for (int i = 0; i < QTR; i++) step(1, 8'hF8);
    // mixed random stream
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [7:0] b;
      r = $urandom_range(0, 99);
      if (r < 45) b = 8'hF8;
      else if (r < 80) b = 8'($urandom_range(0, 247));
      else if (r < 83) b = 8'hFA;
      else if (r < 86) b = 8'hFB;
      else if (r < 89) b = 8'hFC;
      else if (r < 91) b = 8'hFF;
      else if (r < 94) b = 8'hFE;
      else if (r < 96) b = (r[0]) ? 8'hF9 : 8'hFD;
      else b = 8'hF8;
      step(r != 99, b);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule